// File: doc/BRIEF.md
# Receiver Lock Fallback Controller

This block watches the lock flag and the sample-rate fault flag of a digital audio receiver. It produces two outputs. The first is an error flag that rises at once on any fault. The second is a source select for the main audio port, which chooses between the receiver path and a local ADC path.

The error flag clears only after enough block-start (preamble B) strobes arrive with no fault in between. A 2-bit field picks how many strobes are needed. While the receiver is unlocked, a millisecond timer runs up to a programmable start-up wait. If the receiver is still unlocked when the wait ends, the main port moves to the ADC. The port goes back to the receiver once lock is held and the error flag has cleared.

At 48 kHz the default of 48 strobes gives a hold-off of about 192 ms. The frame decoder and the clock recovery loop sit outside this block.

Top module: `lock_fallback_ctrl`

## Requirements
- R1: A fault is `rx_locked` low or `rate_fault` high. Any cycle with a fault makes `error_flag` 1 from the next cycle on.
- R2: The release target is 48 strobes for `release_sel` 00, 12 for 01, 6 for 10 and 3 for 11. `error_flag` falls the cycle after the strobe that makes the count equal the target.
- R3: Only `preamble_b` strobes sampled in fault-free cycles are counted. A fault that arrives during counting resets the count to zero and keeps `error_flag` at 1.
- R4: The start-up wait is 25 ms for `wait_sel` 00, 50 for 01, 100 for 10 and 200 for 11. Only `ms_tick` pulses sampled while unlocked advance the timer. `src_adc` goes to 1 two cycles after the tick that reaches the wait, provided lock is still absent.
- R5: Any cycle with `rx_locked` high clears the wait timer, so the next unlock counts from zero.
- R6: `src_adc` returns to 0 one cycle after a cycle in which `rx_locked` is 1 and `error_flag` is 0. Until then it holds its value.
- R7: The release target is sampled from `release_sel` in every fault cycle. The wait limit is sampled from `wait_sel` in every locked cycle. After reset these are 48 and 25, and a field change made between samples has no effect on a count in progress.
- R8: A rate fault while locked raises `error_flag` but never moves `src_adc` to 1.
- R9: During and right after reset, `error_flag` is 1 and `src_adc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_locked | input | 1 | Receiver lock status |
| rate_fault | input | 1 | Sample rate changed or out of range |
| preamble_b | input | 1 | One-cycle strobe at each block start |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| wait_sel | input | 2 | Start-up wait code |
| release_sel | input | 2 | Error release count code |
| error_flag | output | 1 | Receiver data not trusted |
| src_adc | output | 1 | 1: main port fed from ADC, 0: from receiver |

## Verification
The hardest case to reach is a count that must not be affected by a change made in the middle of it. One example is a new `release_sel` value written while a release count is running, with no fault to resample it. Another is the release target in force straight after reset, before any fault has captured a field.

To reach these, the bench holds lock through reset with a non-default code on the field. This shows the 48-strobe default at work. It also changes the field partway through a 3-strobe count, and it breaks a count with a one-cycle rate fault. A second unlock that follows a short relock shows that the timer restarts.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam int REL_MAX = 48;
  localparam int WAIT_MAX = 200;
  localparam int REL_W = $clog2(REL_MAX + 1);
  localparam int WAIT_W = $clog2(WAIT_MAX + 1);

  function automatic logic [REL_W-1:0] release_target(input logic [1:0] code);
    case (code)
      2'b00: release_target = REL_W'(48);
      2'b01: release_target = REL_W'(12);
      2'b10: release_target = REL_W'(6);
      default: release_target = REL_W'(3);
    endcase
  endfunction

  function automatic logic [WAIT_W-1:0] wait_limit(input logic [1:0] code);
    wait_limit = WAIT_W'(25) << code;
  endfunction
endpackage

// File: rtl/lfc_release_counter.sv
module lfc_release_counter
  import lfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fault,
  input  logic       strobe,
  input  logic [1:0] sel,
  output logic       error_q
);
  logic [REL_W-1:0] cnt_q, target_q;
  logic             hit;

  assign hit = strobe && (cnt_q + REL_W'(1) == target_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      error_q  <= 1'b1;
      cnt_q    <= '0;
      target_q <= release_target(2'b00);
    end else if (fault) begin
      error_q  <= 1'b1;
      cnt_q    <= '0;
      target_q <= release_target(sel);
    end else if (error_q && strobe) begin
      if (hit) begin
        error_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + REL_W'(1);
      end
    end
  end

  // R1
  a_r1_fault_sets_error: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> error_q);
  // R3
  a_r3_fault_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> cnt_q == '0);
  // R2
  a_r2_count_below_target: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < target_q);
  a_r2_release_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(error_q) |-> $past(strobe) && !$past(fault));
endmodule

// File: rtl/lfc_wait_timer.sv
module lfc_wait_timer
  import lfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       locked,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       expired_q
);
  logic [WAIT_W-1:0] cnt_q, limit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
      limit_q   <= wait_limit(2'b00);
    end else if (locked) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
      limit_q   <= wait_limit(sel);
    end else if (tick && !expired_q) begin
      if (cnt_q + WAIT_W'(1) == limit_q) expired_q <= 1'b1;
      cnt_q <= cnt_q + WAIT_W'(1);
    end
  end

  // R5
  a_r5_lock_clears_timer: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> !expired_q && cnt_q == '0);
  // R4
  a_r4_expire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired_q) |-> $past(tick) && !$past(locked));
endmodule

// File: rtl/lock_fallback_ctrl.sv
module lock_fallback_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_locked,
  input  logic       rate_fault,
  input  logic       preamble_b,
  input  logic       ms_tick,
  input  logic [1:0] wait_sel,
  input  logic [1:0] release_sel,
  output logic       error_flag,
  output logic       src_adc
);
  logic fault;
  logic wait_done;
  logic src_q;

  assign fault = !rx_locked || rate_fault;

  lfc_release_counter u_release (
    .clk(clk), .rst_n(rst_n), .fault(fault), .strobe(preamble_b),
    .sel(release_sel), .error_q(error_flag)
  );

  lfc_wait_timer u_wait (
    .clk(clk), .rst_n(rst_n), .locked(rx_locked), .tick(ms_tick),
    .sel(wait_sel), .expired_q(wait_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                         src_q <= 1'b0;
    else if (wait_done && !rx_locked)   src_q <= 1'b1;
    else if (rx_locked && !error_flag)  src_q <= 1'b0;
  end

  assign src_adc = src_q;

  // R4, R8
  a_r4_switch_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_q) |-> $past(wait_done) && !$past(rx_locked));
  // R6
  a_r6_return_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(src_q) |-> $past(rx_locked) && !$past(error_flag));
endmodule

// File: tb/test_lock_fallback_ctrl.sv
module test_lock_fallback_ctrl;
  localparam int CLK_PERIOD = 10;
  // entry: {code[1:0], release strobes[5:0], wait ms[7:0]}
  localparam logic [15:0] VECS [4] = '{
    {2'b00, 6'd48, 8'd25}, {2'b01, 6'd12, 8'd50},
    {2'b10, 6'd6, 8'd100}, {2'b11, 6'd3, 8'd200}
  };

  logic clk = 0, rst_n = 0, rx_locked = 0, rate_fault = 0, preamble_b = 0, ms_tick = 0;
  logic [1:0] wait_sel = 0, release_sel = 0;
  logic error_flag, src_adc;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_fallback_ctrl i_lock_fallback_ctrl (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic strobes(input int n);
    for (int k = 0; k < n; k++) begin
      preamble_b = 1; cyc(1); preamble_b = 0; cyc(1);
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      ms_tick = 1; cyc(1); ms_tick = 0; cyc(1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R9 / R7: reset with lock held and code 11 on the field; default 48 must apply
    rx_locked = 1; release_sel = 2'b11;
    cyc(3);
    chk("R9 error in reset", error_flag, 1'b1);
    chk("R9 src in reset", src_adc, 1'b0);
    rst_n = 1; cyc(1);
    chk("R9 error after reset", error_flag, 1'b1);
    strobes(47);
    chk("R7 default target 48 not reached", error_flag, 1'b1);
    strobes(1);
    chk("R7 default target 48 releases", error_flag, 1'b0);

    // table walk: R2 and R4 for every code
    for (int i = 0; i < 4; i++) begin
      wait_sel = VECS[i][15:14]; release_sel = VECS[i][15:14];
      cyc(2);
      rx_locked = 0; cyc(2);
      chk("R1 unlock raises error", error_flag, 1'b1);
      ticks(int'(VECS[i][7:0]) - 1);
      chk("R4 before wait ends", src_adc, 1'b0);
      ticks(1); cyc(1);
      chk("R4 wait ends to ADC", src_adc, 1'b1);
      rx_locked = 1; cyc(1);
      strobes(int'(VECS[i][13:8]) - 1);
      chk("R2 one short of target", error_flag, 1'b1);
      chk("R6 src held while error", src_adc, 1'b1);
      strobes(1);
      chk("R2 release at target", error_flag, 1'b0);
      chk("R6 src back to receiver", src_adc, 1'b0);
    end

    // R3: rate fault mid-count restarts, and strobes during it are ignored
    release_sel = 2'b11;
    rate_fault = 1; cyc(1);
    chk("R1 rate fault raises error", error_flag, 1'b1);
    rate_fault = 0;
    strobes(2);
    rate_fault = 1; preamble_b = 1; cyc(1); rate_fault = 0; preamble_b = 0; cyc(1);
    strobes(2);
    chk("R3 restart after fault", error_flag, 1'b1);
    strobes(1);
    chk("R3 release after full recount", error_flag, 1'b0);

    // R7: field change mid-count has no effect
    rate_fault = 1; cyc(1); rate_fault = 0;
    strobes(1);
    release_sel = 2'b00;
    strobes(1);
    chk("R7 mid-count change ignored, not yet", error_flag, 1'b1);
    strobes(1);
    chk("R7 mid-count change ignored, released", error_flag, 1'b0);

    // R8: rate fault while locked never selects ADC
    wait_sel = 2'b00; cyc(1);
    rate_fault = 1;
    ticks(60);
    chk("R8 rate fault keeps receiver", src_adc, 1'b0);
    chk("R8 rate fault error", error_flag, 1'b1);
    rate_fault = 0; release_sel = 2'b11;
    rate_fault = 1; cyc(1); rate_fault = 0;
    strobes(3);
    chk("R2 release code 11", error_flag, 1'b0);

    // R5: relock resets timer
    rx_locked = 0; cyc(1);
    ticks(20);
    rx_locked = 1; cyc(2);
    rx_locked = 0; cyc(1);
    ticks(20);
    chk("R5 timer restarted", src_adc, 1'b0);
    ticks(5); cyc(1);
    chk("R5 full wait after restart", src_adc, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule